// File: doc/BRIEF.md
# Dual-Issue Group Pairing Checker

This block sits at the decode stage of a two-wide in-order core. Each cycle it sees two candidate instructions in program order, the older one in the first slot. Each candidate carries a valid bit, a three-bit issue-group code and a lock length. The block decides whether none, only the older, or both may issue. Two instructions may pair only if their groups do not compete for a shared execution resource. These resources are the integer unit, the branch target adder, the load-store issue port and the first floating-point stage.

Some instructions must issue alone. The block calls this the solo class. A solo instruction can also keep the decode stage closed for several cycles. Its lock length gives the total number of cycles the stage stays closed, counting the issue cycle itself. For example, a subroutine return uses 2, an exception return uses 5 and a call uses 16. While that hold lasts, a down-counter keeps both issue outputs low and raises `busy`. The issue outputs are combinational in the current inputs and the counter state. Only the counter is registered.

Top module: `ipair_issue`

## Requirements
- R1: A synchronous active-high `rst` clears the lock counter, so `busy` is 0 in the first cycle after reset.
- R2: When `busy` is 0, `issue_first` equals `slot0_valid`. `issue_second` can be 1 only in a cycle where `issue_first` is 1, so a younger instruction never issues ahead of an older one.
- R3: Group codes are NIL=0, MT=1, EX=2, BR=3, LS=4, FE=5 and SOLO=6. Code 7 is reserved and is handled exactly like SOLO.
- R4: A SOLO instruction in either slot never issues together with another instruction: `issue_second` is 0 whenever either group is SOLO.
- R5: EX+EX, EX+BR and BR+EX pairs do not dual-issue. The integer unit and the branch path share an execution resource.
- R6: BR+BR, BR+LS and LS+BR pairs do not dual-issue. They compete for the branch target adder and the issue-cycle load-store resource.
- R7: LS+LS and FE+FE pairs do not dual-issue.
- R8: Every other pair of non-SOLO groups dual-issues when both slots are valid. This includes any pair that has an MT or NIL instruction.
- R9: When a SOLO instruction issues from slot 0 with lock length L ≥ 2, `busy` is 1 and both issue outputs are 0 for the next L−1 cycles. Issue resumes in the cycle after that. L of 0 or 1 adds no stall.
- R10: The lock length of a non-SOLO instruction, and the lock length in slot 1, have no effect on `busy`.
- R11: While `busy` is 1, both issue outputs stay 0 whatever the candidates are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0_valid | input | 1 | Older candidate present |
| slot0_group | input | 3 | Older candidate issue-group code |
| slot0_lock | input | LOCK_W | Older candidate decode hold length in cycles |
| slot1_valid | input | 1 | Younger candidate present |
| slot1_group | input | 3 | Younger candidate issue-group code |
| slot1_lock | input | LOCK_W | Younger candidate hold length (unused when not issued alone) |
| issue_first | output | 1 | Older candidate issues this cycle |
| issue_second | output | 1 | Younger candidate issues this cycle |
| busy | output | 1 | Decode stage held by an earlier solo instruction |

## Verification
The bench checks all 64 ordered group pairs, including the reserved code, against a table it builds from resource masks. A design that treats one of the conflicts as only one-directional, such as BR+LS versus LS+BR, would dual-issue one of the orders. The bench runs holds of 2, 5 and 16 cycles with candidates waiting. A counter that is off by one would either release a cycle early or stall a cycle too long. It also checks a valid younger slot behind an empty older slot, where a design without the ordering rule would issue out of order. Lock lengths 0 and 1, and large lock values on non-solo or slot-1 instructions, must leave `busy` low.

// File: rtl/ipair_pkg.sv
`timescale 1ns/1ps
package ipair_pkg;
  typedef enum logic [2:0] {
    GRP_NIL = 3'd0,
    GRP_MT  = 3'd1,
    GRP_EX  = 3'd2,
    GRP_BR  = 3'd3,
    GRP_LS  = 3'd4,
    GRP_FE  = 3'd5,
    GRP_CO  = 3'd6,
    GRP_RSV = 3'd7
  } grp_e;

  localparam int GRP_W = 3;

  // Instructions that must occupy both decode slots (R3: 7 behaves as 6)
  function automatic logic grp_is_solo(input logic [GRP_W-1:0] g);
    return (g == GRP_CO) || (g == GRP_RSV);
  endfunction

  // Pair conflict between an older (a) and younger (b) instruction
  function automatic logic grp_pair_clash(input logic [GRP_W-1:0] a,
                                          input logic [GRP_W-1:0] b);
    logic ex_a, ex_b, br_a, br_b, ls_a, ls_b, fe_a, fe_b;
    ex_a = (a == GRP_EX); ex_b = (b == GRP_EX);
    br_a = (a == GRP_BR); br_b = (b == GRP_BR);
    ls_a = (a == GRP_LS); ls_b = (b == GRP_LS);
    fe_a = (a == GRP_FE); fe_b = (b == GRP_FE);
    if (grp_is_solo(a) || grp_is_solo(b)) return 1'b1;
    return (ex_a && ex_b) || (ex_a && br_b) || (br_a && ex_b) ||
           (br_a && br_b) || (br_a && ls_b) || (ls_a && br_b) ||
           (ls_a && ls_b) || (fe_a && fe_b);
  endfunction
endpackage

// File: rtl/ipair_pair_rules.sv
`timescale 1ns/1ps
module ipair_pair_rules
  import ipair_pkg::*;
(
  input  logic [GRP_W-1:0] grp_old,
  input  logic [GRP_W-1:0] grp_young,
  output logic             clash
);
  always_comb begin
    clash = grp_pair_clash(grp_old, grp_young);
  end

  // R8
  always_comb begin
    mt_pairs_chk: assert (!((grp_old == GRP_MT) && !grp_is_solo(grp_young)) || !clash)
      else $error("MT older instruction reported as clashing");
  end

  // R4
  always_comb begin
    solo_clash_chk: assert (!(grp_is_solo(grp_old) || grp_is_solo(grp_young)) || clash)
      else $error("solo instruction not reported as clashing");
  end
endmodule

// File: rtl/ipair_lock_ctr.sv
`timescale 1ns/1ps
module ipair_lock_ctr #(
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOCK_W-1:0] load_len,
  output logic              busy
);
  logic [LOCK_W-1:0] remain;
  logic [LOCK_W-1:0] reload_val;

  // Cycles still held after the issue cycle: len-1, saturating at zero
  always_comb begin
    reload_val = (load_len > LOCK_W'(1)) ? load_len - LOCK_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= reload_val;
    else if (remain != '0)  remain <= remain - LOCK_W'(1);
  end

  assign busy = (remain != '0);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (remain == $past(remain) - LOCK_W'(1)))
    else $error("lock counter did not step down");

  // R11
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy)
    else $error("lock reloaded while still held");
endmodule

// File: rtl/ipair_issue.sv
`timescale 1ns/1ps
module ipair_issue
  import ipair_pkg::*;
#(
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot0_valid,
  input  logic [2:0]        slot0_group,
  input  logic [LOCK_W-1:0] slot0_lock,
  input  logic              slot1_valid,
  input  logic [2:0]        slot1_group,
  input  logic [LOCK_W-1:0] slot1_lock,
  output logic              issue_first,
  output logic              issue_second,
  output logic              busy
);
  logic pair_clash;
  logic first_go;
  logic second_go;
  logic solo_fire;
  logic slot1_lock_unused;

  ipair_pair_rules u_rules (
    .grp_old   (slot0_group),
    .grp_young (slot1_group),
    .clash     (pair_clash)
  );

  always_comb begin
    first_go  = slot0_valid && !busy;
    second_go = first_go && slot1_valid && !pair_clash;
    solo_fire = first_go && grp_is_solo(slot0_group);
  end

  // Slot 1 never issues alone, so its hold length is never loaded (R10)
  assign slot1_lock_unused = |slot1_lock;

  ipair_lock_ctr #(.LOCK_W(LOCK_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .load     (solo_fire),
    .load_len (slot0_lock),
    .busy     (busy)
  );

  assign issue_first  = first_go;
  assign issue_second = second_go;

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!issue_first && !issue_second))
    else $error("issue while decode held");

  // R2
  order_keep_chk: assert property (@(posedge clk) disable iff (rst)
    issue_second |-> issue_first)
    else $error("younger slot issued without older");

  // R4
  solo_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_first && (grp_is_solo(slot0_group) || grp_is_solo(slot1_group))) |-> !issue_second)
    else $error("solo instruction paired");

  // R5
  ex_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (slot0_group == GRP_EX && (slot1_group == GRP_EX || slot1_group == GRP_BR)) |-> !issue_second)
    else $error("EX paired with EX or BR");

  // R9
  hold_start_chk: assert property (@(posedge clk) disable iff (rst)
    (solo_fire && slot0_lock > LOCK_W'(1)) |=> busy)
    else $error("hold did not start");

  // R9
  no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (first_go && !(solo_fire && slot0_lock > LOCK_W'(1))) |=> !busy)
    else $error("unexpected hold");
endmodule

// File: tb/tb_ipair_issue.sv
`timescale 1ns/1ps
module tb_ipair_issue;
  localparam int LOCK_W = 5;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst;
  logic s0v, s1v;
  logic [2:0] s0g, s1g;
  logic [LOCK_W-1:0] s0l, s1l;
  logic iss0, iss1, bsy;

  always #2.5 clk = ~clk;

  ipair_issue #(.LOCK_W(LOCK_W)) dut (
    .clk(clk), .rst(rst),
    .slot0_valid(s0v), .slot0_group(s0g), .slot0_lock(s0l),
    .slot1_valid(s1v), .slot1_group(s1g), .slot1_lock(s1l),
    .issue_first(iss0), .issue_second(iss1), .busy(bsy)
  );

  typedef struct {
    logic  f;
    logic  s;
    logic  b;
    string tag;
  } exp_t;

  exp_t sb[$];
  int compared = 0;
  int mismatched = 0;
  int hold_left = 0;
  bit done = 0;

  // Resource masks: bit0 integer, bit1 branch adder, bit2 ls port, bit3 fpu stage, bit4 whole decode
  function automatic logic [4:0] res_of(input logic [2:0] g);
    case (g)
      3'd2: return 5'b00001;
      3'd3: return 5'b00111;
      3'd4: return 5'b00100;
      3'd5: return 5'b01000;
      3'd6, 3'd7: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic ref_pairs(input logic [2:0] a, input logic [2:0] b);
    logic [4:0] ra, rb;
    ra = res_of(a); rb = res_of(b);
    if (ra[4] || rb[4]) return 1'b0;
    return (ra & rb) == 5'b0;
  endfunction

  task automatic step(input logic av, input logic [2:0] ag, input int al,
                      input logic bv, input logic [2:0] bg, input int bl,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    s0v = av; s0g = ag; s0l = LOCK_W'(al);
    s1v = bv; s1g = bg; s1l = LOCK_W'(bl);
    e.b = (hold_left != 0);
    e.f = av && (hold_left == 0);
    e.s = e.f && bv && ref_pairs(ag, bg);
    e.tag = tag;
    sb.push_back(e);
    if (e.f && (ag == 3'd6 || ag == 3'd7)) hold_left = (al > 1) ? al - 1 : 0;
    else if (hold_left > 0) hold_left--;
  endtask

  // Monitor: compares between edges
  always @(negedge clk) begin
    if (!rst && sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (iss0 !== e.f || iss1 !== e.s || bsy !== e.b) begin
        mismatched++;
        $display("FAIL %s: got first=%b second=%b busy=%b expected first=%b second=%b busy=%b",
                 e.tag, iss0, iss1, bsy, e.f, e.s, e.b);
      end
    end
  end

  initial begin
    #(MAX_CYC * 5.0);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    s0v = 0; s1v = 0; s0g = 0; s1g = 0; s0l = 0; s1l = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: busy low right after reset
    step(0, 3'd0, 0, 0, 3'd0, 0, "R1 reset idle");
    // R3 R4 R5 R6 R7 R8: every ordered pair, lock 0 so no hold
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(1, 3'(a), 0, 1, 3'(b), 0, $sformatf("R3-table R4 R5 R6 R7 R8 pair %0d,%0d", a, b));
      end
    end
    // R2: empty older slot blocks younger
    step(0, 3'd1, 0, 1, 3'd1, 0, "R2 empty older");
    step(1, 3'd2, 0, 0, 3'd4, 0, "R2 empty younger");
    // R9: lock 1 gives no stall
    step(1, 3'd6, 1, 1, 3'd1, 0, "R9 lock one");
    step(1, 3'd1, 0, 1, 3'd2, 0, "R9 after lock one");
    // R10: long lock on non-solo and on slot 1 ignored
    step(1, 3'd2, 16, 1, 3'd6, 31, "R10 lock ignored");
    step(1, 3'd1, 31, 1, 3'd4, 31, "R10 still free");
    // R9 R11: holds of 2, 5, 16 with candidates waiting
    for (int h = 0; h < 3; h++) begin
      int len;
      len = (h == 0) ? 2 : (h == 1) ? 5 : 16;
      step(1, 3'd6, len, 1, 3'd1, 0, $sformatf("R9 solo lock %0d", len));
      for (int k = 0; k < len; k++) begin
        step(1, 3'd1, 0, 1, 3'd2, 0, $sformatf("R9 R11 hold %0d cycle %0d", len, k));
      end
    end
    // R3: reserved code holds like solo
    step(1, 3'd7, 3, 1, 3'd1, 0, "R3 reserved hold");
    step(1, 3'd6, 9, 1, 3'd1, 0, "R11 solo ignored while held");
    step(1, 3'd5, 0, 1, 3'd5, 0, "R11 held then R7");
    step(1, 3'd5, 0, 1, 3'd4, 0, "R8 FE LS pair");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule